// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block holds the programmable state of a small interrupt distributor that serves up to 128 interrupt lines and up to eight CPU interfaces. Software reaches it over a simple word-wide register bus that carries a byte offset, write data, a write strobe and the number of the CPU making the access. Behind that bus the block keeps a global distributor enable, one enable bit and one pending bit per interrupt, an 8-bit priority per interrupt, and a one-bit trigger mode per interrupt (1 = edge, 0 = level).

Interrupts 0 to 31 are private. Each CPU has its own copy of their enable, pending and mode state, and the copy that an access reaches is the one that belongs to the CPU named on the bus. Interrupts 32 and up are shared by all CPUs. The enable, pending and mode bits drive flat output vectors to the neighbouring blocks that evaluate pending interrupts and route them. A one-cycle `state_changed_o` pulse tells the pending evaluator when to recompute. Interrupt routing to CPUs and the software-interrupt trigger are handled outside this block, so their offsets read zero here.

Top module: `dist_regs`

## Requirements
- R1: After reset the distributor is disabled. In every CPU bank, interrupts 0-15 are enabled and in edge mode, and interrupts 16-31 are disabled and in level mode. All shared enables, all pending bits and all shared mode bits are 0, and `bus_rdata` is 0.
- R2: At offset 0x000 only bit 0 is stored, as the distributor enable. A read returns it in bit 0 with zeros above it, and `dist_en_o` follows it.
- R3: Offset 0x004 is read-only and returns (CPUs - 1) in bits [7:5] and (interrupts / 32 - 1) in bits [4:0], which is 0xE3 with the default parameters. Offset 0x008 always returns 0x4B00043B. Writes to either offset change nothing.
- R4: The enable bits are set by writing ones to 0x100+4w and cleared by writing ones to 0x180+4w. The pending bits are set at 0x200+4w and cleared at 0x280+4w. Bit b of word w is interrupt 32w+b. Zero bits in the written data leave their bits unchanged. Any of these offsets reads back the current word.
- R5: After any write to the clear-enable word 0 (0x180), bits [15:0] of the accessing CPU's enable word are 1.
- R6: Word 0 of the enable and pending arrays, configuration words 0 and 1, and priority words 0-7 reach the bank of the CPU given on `bus_cpu`. All higher words reach storage that every CPU shares.
- R7: Priority word w sits at 0x400+4w and holds four 8-bit priorities. Byte i (bits 8i+7:8i) belongs to interrupt 4w+i. The whole word is written and read back.
- R8: Configuration word k at 0xC00+4k covers interrupts 16k to 16k+15. For entry i, bit 2i+1 reads the stored mode bit (1 = edge) and bit 2i reads 0. A write stores only bits 2i+1.
- R9: A write to configuration word 0 sets the mode bits of interrupts 0-15 in the accessing CPU's bank to 1, whatever the data.
- R10: The group range (0x080), the set-active and clear-active ranges (0x300, 0x380), the routing range (0x800), the trigger word (0xF00) and every unmapped offset read 0. Writes to them change no state and no output.
- R11: `state_changed_o` is high for exactly the one cycle after a write to the control word or to a set/clear enable or set/clear pending word. It stays low after any other access.
- R12: Read data appears on `bus_rdata` in the cycle after the read access and holds until the next read. Writes take effect on the output vectors in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Number of the accessing CPU, selects the private bank |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| dist_en_o | output | 1 | Distributor enable |
| irq_en_priv_o | output | NUM_CPUS*32 | Private enables, bit 32c+i is interrupt i of CPU c |
| irq_pend_priv_o | output | NUM_CPUS*32 | Private pending bits, same layout |
| irq_edge_priv_o | output | NUM_CPUS*32 | Private mode bits (1 = edge), same layout |
| irq_en_shared_o | output | NUM_IRQS-32 | Shared enables, bit j is interrupt 32+j |
| irq_pend_shared_o | output | NUM_IRQS-32 | Shared pending bits |
| irq_edge_shared_o | output | NUM_IRQS-32 | Shared mode bits |
| state_changed_o | output | 1 | One-cycle pulse after a write to control, enable or pending state |

## Verification
An access that lands in the wrong bank, or a wrong set/clear mask, shows up on the flat enable, pending and mode vectors one cycle after the write. The bench compares every bit of those vectors against its model after every access, so such a fault is caught within two cycles. A wrong priority slot or a broken compression of the mode field is visible only through read-back, so the random mix reads those ranges often with every CPU number. A missing SGI force, or a RAZ/WI offset that has a side effect, changes a vector or a pulse at once.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;

  // Word offsets of the register groups (byte offset / 4)
  localparam int W_CTRL   = 'h000 >> 2;
  localparam int W_TYPE   = 'h004 >> 2;
  localparam int W_IDENT  = 'h008 >> 2;
  localparam int W_EN_SET = 'h100 >> 2;
  localparam int W_EN_CLR = 'h180 >> 2;
  localparam int W_PD_SET = 'h200 >> 2;
  localparam int W_PD_CLR = 'h280 >> 2;
  localparam int W_PRIO   = 'h400 >> 2;
  localparam int W_CFG    = 'hC00 >> 2;

  localparam logic [31:0] IDENT_VAL = 32'h4B00043B;
  localparam logic [31:0] SGI_BITS  = 32'h0000FFFF;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_IDENT,
    RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR,
    RG_PRIO, RG_CFG
  } region_e;

  // Keep the odd (upper) bit of each 2-bit mode pair
  function automatic logic [15:0] cfg_pack(input logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[2*i+1];
    return r;
  endfunction

  // Place each stored bit at 2i+1, zero at 2i
  function automatic logic [31:0] cfg_unpack(input logic [15:0] h);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) r[2*i+1] = h[i];
    return r;
  endfunction

endpackage

// File: rtl/dist_addr_decode.sv
module dist_addr_decode
  import dist_regs_pkg::*;
#(
  parameter int NUM_IRQS = 128,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  widx
);

  localparam int BM_WORDS   = NUM_IRQS / 32;
  localparam int PRIO_WORDS = NUM_IRQS / 4;
  localparam int CFG_WORDS  = NUM_IRQS / 16;

  int wi;
  assign wi = int'(addr) >> 2;

  function automatic logic in_win(input int w, input int base, input int len);
    return (w >= base) && (w < base + len);
  endfunction

  always_comb begin
    region = RG_NONE;
    widx   = '0;
    if (wi == W_CTRL) begin
      region = RG_CTRL;
    end else if (wi == W_TYPE) begin
      region = RG_TYPE;
    end else if (wi == W_IDENT) begin
      region = RG_IDENT;
    end else if (in_win(wi, W_EN_SET, BM_WORDS)) begin
      region = RG_EN_SET;
      widx   = IDX_W'(wi - W_EN_SET);
    end else if (in_win(wi, W_EN_CLR, BM_WORDS)) begin
      region = RG_EN_CLR;
      widx   = IDX_W'(wi - W_EN_CLR);
    end else if (in_win(wi, W_PD_SET, BM_WORDS)) begin
      region = RG_PD_SET;
      widx   = IDX_W'(wi - W_PD_SET);
    end else if (in_win(wi, W_PD_CLR, BM_WORDS)) begin
      region = RG_PD_CLR;
      widx   = IDX_W'(wi - W_PD_CLR);
    end else if (in_win(wi, W_PRIO, PRIO_WORDS)) begin
      region = RG_PRIO;
      widx   = IDX_W'(wi - W_PRIO);
    end else if (in_win(wi, W_CFG, CFG_WORDS)) begin
      region = RG_CFG;
      widx   = IDX_W'(wi - W_CFG);
    end
  end

endmodule

// File: rtl/dist_bitbank.sv
module dist_bitbank #(
  parameter int          NUM_CPUS  = 8,
  parameter int          NUM_WORDS = 4,
  parameter int          CPU_W     = 3,
  parameter int          IDX_W     = 5,
  parameter logic [31:0] RST_PRIV  = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [CPU_W-1:0]           cpu,
  input  logic [IDX_W-1:0]           idx,
  input  logic [31:0]                wr_mask,
  input  logic [31:0]                wr_val,
  output logic [31:0]                rd_word,
  output logic [NUM_CPUS*32-1:0]     priv_o,
  output logic [(NUM_WORDS-1)*32-1:0] shared_o
);

  localparam int NSH = NUM_WORDS - 1;

  // Private word 0, one copy per CPU
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_priv
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= RST_PRIV;
      end else if (wr_en && idx == '0 && int'(cpu) == c) begin
        word_q <= (word_q & ~wr_mask) | (wr_val & wr_mask);
      end
    end
    assign priv_o[c*32 +: 32] = word_q;
  end

  // Shared words 1..NUM_WORDS-1
  for (genvar j = 0; j < NSH; j++) begin : g_shared
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (wr_en && int'(idx) == j + 1) begin
        word_q <= (word_q & ~wr_mask) | (wr_val & wr_mask);
      end
    end
    assign shared_o[j*32 +: 32] = word_q;
  end

  always_comb begin
    rd_word = '0;
    if (idx == '0) begin
      if (int'(cpu) < NUM_CPUS) rd_word = priv_o[int'(cpu)*32 +: 32];
    end else if (int'(idx) < NUM_WORDS) begin
      rd_word = shared_o[(int'(idx)-1)*32 +: 32];
    end
  end

endmodule

// File: rtl/dist_prio_ram.sv
module dist_prio_ram #(
  parameter int DEPTH = 88,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];

  // Single port; the read register only moves on a read
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/dist_regs.sv
module dist_regs
  import dist_regs_pkg::*;
#(
  parameter int NUM_IRQS = 128,
  parameter int NUM_CPUS = 8,
  parameter int ADDR_W   = 12,
  parameter int CPU_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic [CPU_W-1:0]          bus_cpu,
  output logic [31:0]               bus_rdata,
  output logic                      dist_en_o,
  output logic [NUM_CPUS*32-1:0]    irq_en_priv_o,
  output logic [NUM_CPUS*32-1:0]    irq_pend_priv_o,
  output logic [NUM_CPUS*32-1:0]    irq_edge_priv_o,
  output logic [NUM_IRQS-33:0]      irq_en_shared_o,
  output logic [NUM_IRQS-33:0]      irq_pend_shared_o,
  output logic [NUM_IRQS-33:0]      irq_edge_shared_o,
  output logic                      state_changed_o
);

  localparam int BM_WORDS    = NUM_IRQS / 32;
  localparam int PRIO_WORDS  = NUM_IRQS / 4;
  localparam int PRIO_BANKED = 8;
  localparam int PRIO_DEPTH  = NUM_CPUS * PRIO_BANKED + PRIO_WORDS - PRIO_BANKED;
  localparam int PA_W        = $clog2(PRIO_DEPTH);
  localparam int IDX_W       = $clog2(PRIO_WORDS);
  localparam logic [31:0] TYPE_VAL = (32'(NUM_CPUS - 1) << 5) | 32'(BM_WORDS - 1);

  // ---------------- decode ----------------
  region_e          region;
  logic [IDX_W-1:0] widx;
  logic             acc_wr, acc_rd, widx0;

  dist_addr_decode #(
    .NUM_IRQS(NUM_IRQS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .region(region), .widx(widx)
  );

  assign acc_wr = bus_valid &&  bus_write;
  assign acc_rd = bus_valid && !bus_write;
  assign widx0  = (widx == '0);

  // ---------------- enable bits ----------------
  logic        en_we;
  logic [31:0] en_mask, en_val, en_rd;

  always_comb begin
    en_we = acc_wr && (region == RG_EN_SET || region == RG_EN_CLR);
    if (region == RG_EN_SET) begin
      en_mask = bus_wdata;
      en_val  = '1;
    end else begin
      // clear; private word 0 keeps its SGI enables on
      en_mask = bus_wdata | (widx0 ? SGI_BITS : '0);
      en_val  = widx0 ? SGI_BITS : '0;
    end
  end

  dist_bitbank #(
    .NUM_CPUS(NUM_CPUS), .NUM_WORDS(BM_WORDS), .CPU_W(CPU_W),
    .IDX_W(IDX_W), .RST_PRIV(SGI_BITS)
  ) u_en (
    .clk(clk), .rst(rst), .wr_en(en_we), .cpu(bus_cpu), .idx(widx),
    .wr_mask(en_mask), .wr_val(en_val), .rd_word(en_rd),
    .priv_o(irq_en_priv_o), .shared_o(irq_en_shared_o)
  );

  // ---------------- pending bits ----------------
  logic        pd_we;
  logic [31:0] pd_val, pd_rd;

  assign pd_we  = acc_wr && (region == RG_PD_SET || region == RG_PD_CLR);
  assign pd_val = (region == RG_PD_SET) ? '1 : '0;

  dist_bitbank #(
    .NUM_CPUS(NUM_CPUS), .NUM_WORDS(BM_WORDS), .CPU_W(CPU_W),
    .IDX_W(IDX_W), .RST_PRIV('0)
  ) u_pd (
    .clk(clk), .rst(rst), .wr_en(pd_we), .cpu(bus_cpu), .idx(widx),
    .wr_mask(bus_wdata), .wr_val(pd_val), .rd_word(pd_rd),
    .priv_o(irq_pend_priv_o), .shared_o(irq_pend_shared_o)
  );

  // ---------------- trigger mode (compressed) ----------------
  logic             cfg_we, cfg_hi;
  logic [15:0]      cfg_bits;
  logic [31:0]      cfg_mask, cfg_val, cfg_rd;
  logic [IDX_W-1:0] cfg_idx;

  always_comb begin
    cfg_we   = acc_wr && region == RG_CFG;
    cfg_hi   = widx[0];
    cfg_idx  = widx >> 1;
    cfg_bits = widx0 ? 16'hFFFF : cfg_pack(bus_wdata);
    cfg_mask = cfg_hi ? 32'hFFFF_0000 : 32'h0000_FFFF;
    cfg_val  = cfg_hi ? {cfg_bits, 16'h0} : {16'h0, cfg_bits};
  end

  dist_bitbank #(
    .NUM_CPUS(NUM_CPUS), .NUM_WORDS(BM_WORDS), .CPU_W(CPU_W),
    .IDX_W(IDX_W), .RST_PRIV(SGI_BITS)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .cpu(bus_cpu), .idx(cfg_idx),
    .wr_mask(cfg_mask), .wr_val(cfg_val), .rd_word(cfg_rd),
    .priv_o(irq_edge_priv_o), .shared_o(irq_edge_shared_o)
  );

  // ---------------- priority storage ----------------
  logic            pr_en;
  logic [PA_W-1:0] pr_addr;
  logic [31:0]     pr_rd;

  assign pr_en = bus_valid && region == RG_PRIO;

  always_comb begin
    if (int'(widx) < PRIO_BANKED)
      pr_addr = PA_W'(int'(bus_cpu) * PRIO_BANKED + int'(widx));
    else
      pr_addr = PA_W'(NUM_CPUS * PRIO_BANKED + int'(widx) - PRIO_BANKED);
  end

  dist_prio_ram #(.DEPTH(PRIO_DEPTH), .AW(PA_W)) u_prio (
    .clk(clk), .en(pr_en), .we(bus_write), .addr(pr_addr),
    .wdata(bus_wdata), .rdata(pr_rd)
  );

  // ---------------- control and change pulse ----------------
  logic dist_en_q, chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_en_q <= 1'b0;
      chg_q     <= 1'b0;
    end else begin
      if (acc_wr && region == RG_CTRL) dist_en_q <= bus_wdata[0];
      chg_q <= acc_wr && (region == RG_CTRL   || region == RG_EN_SET ||
                          region == RG_EN_CLR || region == RG_PD_SET ||
                          region == RG_PD_CLR);
    end
  end

  assign dist_en_o       = dist_en_q;
  assign state_changed_o = chg_q;

  // ---------------- read path ----------------
  logic [31:0] rd_mux, rd_q;
  logic        rd_prio_q;

  always_comb begin
    unique case (region)
      RG_CTRL:              rd_mux = {31'b0, dist_en_q};
      RG_TYPE:              rd_mux = TYPE_VAL;
      RG_IDENT:             rd_mux = IDENT_VAL;
      RG_EN_SET, RG_EN_CLR: rd_mux = en_rd;
      RG_PD_SET, RG_PD_CLR: rd_mux = pd_rd;
      RG_CFG:               rd_mux = cfg_unpack(cfg_hi ? cfg_rd[31:16] : cfg_rd[15:0]);
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      rd_prio_q <= 1'b0;
    end else if (acc_rd) begin
      rd_q      <= rd_mux;
      rd_prio_q <= (region == RG_PRIO);
    end
  end

  assign bus_rdata = rd_prio_q ? pr_rd : rd_q;

endmodule

// File: rtl/dist_regs_chk.sv
module dist_regs_chk #(
  parameter int NUM_IRQS = 128,
  parameter int NUM_CPUS = 8,
  parameter int ADDR_W   = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_rdata,
  input logic                   dist_en_o,
  input logic [NUM_CPUS*32-1:0] irq_en_priv_o,
  input logic [NUM_CPUS*32-1:0] irq_edge_priv_o,
  input logic [NUM_IRQS-33:0]   irq_pend_shared_o,
  input logic                   state_changed_o
);

  localparam logic [NUM_CPUS*32-1:0] SGI_ALL = {NUM_CPUS{32'h0000FFFF}};

  // R5
  sgi_en_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en_priv_o & SGI_ALL) == SGI_ALL);

  // R9
  sgi_edge_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_edge_priv_o & SGI_ALL) == SGI_ALL);

  // R11
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    state_changed_o |-> $past(bus_valid && bus_write));

  // R10
  shared_pend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && bus_write) |-> $stable(irq_pend_shared_o));

  // R2
  dist_en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && bus_write && (bus_addr >> 2) == '0) |-> $stable(dist_en_o));

  // R3
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write && (bus_addr >> 2) == ADDR_W'(2))
      |-> bus_rdata == 32'h4B00043B);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && !bus_write) |-> $stable(bus_rdata));

endmodule

bind dist_regs dist_regs_chk #(
  .NUM_IRQS(NUM_IRQS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_dist_regs.sv
`timescale 1ns/1ps
module tb_dist_regs;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_valid, bus_write;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [2:0]    bus_cpu;
  logic          dist_en_o, state_changed_o;
  logic [255:0]  en_priv, pd_priv, edge_priv;
  logic [95:0]   en_sh, pd_sh, edge_sh;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dist_regs dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .dist_en_o(dist_en_o),
    .irq_en_priv_o(en_priv), .irq_pend_priv_o(pd_priv), .irq_edge_priv_o(edge_priv),
    .irq_en_shared_o(en_sh), .irq_pend_shared_o(pd_sh), .irq_edge_shared_o(edge_sh),
    .state_changed_o(state_changed_o)
  );

  // ---------------- model (defaults: 128 interrupts, 8 CPUs) ----------------
  logic [31:0] m_en [8], m_pd [8], m_cf [8];
  logic [31:0] m_en_s [3], m_pd_s [3], m_cf_s [3];
  logic [31:0] m_pr [8][8];
  logic [31:0] m_pr_s [24];
  logic        m_dist;

  function automatic logic [31:0] unpack16(input logic [15:0] h);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) r[2*i+1] = h[i];
    return r;
  endfunction

  function automatic logic [15:0] pack16(input logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[2*i+1];
    return r;
  endfunction

  function automatic logic [31:0] mdl_read(input int cpu, input logic [11:0] addr);
    int wi = int'(addr) >> 2;
    logic [31:0] v;
    if (wi == 0) return {31'b0, m_dist};
    if (wi == 1) return 32'h000000E3;
    if (wi == 2) return 32'h4B00043B;
    if (wi >= 'h40 && wi < 'h44) return (wi == 'h40) ? m_en[cpu] : m_en_s[wi-'h41];
    if (wi >= 'h60 && wi < 'h64) return (wi == 'h60) ? m_en[cpu] : m_en_s[wi-'h61];
    if (wi >= 'h80 && wi < 'h84) return (wi == 'h80) ? m_pd[cpu] : m_pd_s[wi-'h81];
    if (wi >= 'hA0 && wi < 'hA4) return (wi == 'hA0) ? m_pd[cpu] : m_pd_s[wi-'hA1];
    if (wi >= 'h100 && wi < 'h120)
      return (wi < 'h108) ? m_pr[cpu][wi-'h100] : m_pr_s[wi-'h108];
    if (wi >= 'h300 && wi < 'h308) begin
      v = ((wi - 'h300) < 2) ? m_cf[cpu] : m_cf_s[((wi-'h300)>>1)-1];
      return unpack16((((wi - 'h300) & 1) != 0) ? v[31:16] : v[15:0]);
    end
    return 32'h0;
  endfunction

  // Applies a write to the model; returns the expected change pulse
  function automatic logic mdl_write(input int cpu, input logic [11:0] addr, input logic [31:0] d);
    int wi = int'(addr) >> 2;
    int k;
    logic [15:0] p;
    if (wi == 0) begin m_dist = d[0]; return 1'b1; end
    if (wi >= 'h40 && wi < 'h44) begin
      if (wi == 'h40) m_en[cpu] |= d; else m_en_s[wi-'h41] |= d;
      return 1'b1;
    end
    if (wi >= 'h60 && wi < 'h64) begin
      if (wi == 'h60) m_en[cpu] = (m_en[cpu] & ~d) | 32'h0000FFFF;
      else m_en_s[wi-'h61] &= ~d;
      return 1'b1;
    end
    if (wi >= 'h80 && wi < 'h84) begin
      if (wi == 'h80) m_pd[cpu] |= d; else m_pd_s[wi-'h81] |= d;
      return 1'b1;
    end
    if (wi >= 'hA0 && wi < 'hA4) begin
      if (wi == 'hA0) m_pd[cpu] &= ~d; else m_pd_s[wi-'hA1] &= ~d;
      return 1'b1;
    end
    if (wi >= 'h100 && wi < 'h120) begin
      if (wi < 'h108) m_pr[cpu][wi-'h100] = d; else m_pr_s[wi-'h108] = d;
      return 1'b0;
    end
    if (wi >= 'h300 && wi < 'h308) begin
      k = wi - 'h300;
      p = (k == 0) ? 16'hFFFF : pack16(d);
      if (k < 2) begin
        if ((k & 1) != 0) m_cf[cpu][31:16] = p; else m_cf[cpu][15:0] = p;
      end else begin
        if ((k & 1) != 0) m_cf_s[(k>>1)-1][31:16] = p; else m_cf_s[(k>>1)-1][15:0] = p;
      end
      return 1'b0;
    end
    return 1'b0;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_outputs(input string tag);
    logic [255:0] e_en, e_pd, e_cf;
    logic [95:0]  s_en, s_pd, s_cf;
    for (int c = 0; c < 8; c++) begin
      e_en[c*32 +: 32] = m_en[c];
      e_pd[c*32 +: 32] = m_pd[c];
      e_cf[c*32 +: 32] = m_cf[c];
    end
    for (int j = 0; j < 3; j++) begin
      s_en[j*32 +: 32] = m_en_s[j];
      s_pd[j*32 +: 32] = m_pd_s[j];
      s_cf[j*32 +: 32] = m_cf_s[j];
    end
    chk({tag, " dist_en"}, 256'(dist_en_o), 256'(m_dist));
    chk({tag, " en_priv"}, en_priv, e_en);
    chk({tag, " pend_priv"}, pd_priv, e_pd);
    chk({tag, " edge_priv"}, edge_priv, e_cf);
    chk({tag, " shared"}, {en_sh, pd_sh, edge_sh}, {s_en, s_pd, s_cf});
  endtask

  task automatic do_write(input int cpu, input logic [11:0] addr, input logic [31:0] d);
    logic ep;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = d; bus_cpu = 3'(cpu);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    ep = mdl_write(cpu, addr, d);
    chk("R11 change pulse", 256'(state_changed_o), 256'(ep));
    cmp_outputs("R4 R6 R12 state after write");
  endtask

  task automatic do_read(input int cpu, input logic [11:0] addr, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr; bus_cpu = 3'(cpu);
    bus_wdata = 32'hDEADBEEF;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(tag, 256'(bus_rdata), 256'(mdl_read(cpu, addr)));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [11:0] raz_list [6];
    logic [31:0] held;
    void'($urandom(32'd4242));
    raz_list = '{12'h080, 12'h08C, 12'h300, 12'h384, 12'h800, 12'hF00};
    for (int c = 0; c < 8; c++) begin
      m_en[c] = 32'h0000FFFF; m_pd[c] = '0; m_cf[c] = 32'h0000FFFF;
      for (int w = 0; w < 8; w++) m_pr[c][w] = '0;
    end
    for (int j = 0; j < 3; j++) begin m_en_s[j] = '0; m_pd_s[j] = '0; m_cf_s[j] = '0; end
    for (int j = 0; j < 24; j++) m_pr_s[j] = '0;
    m_dist = 1'b0;

    rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_cpu = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    cmp_outputs("R1 reset");
    chk("R1 rdata after reset", 256'(bus_rdata), 256'h0);
    chk("R1 change pulse idle", 256'(state_changed_o), 256'h0);

    // R7 R6 priority fill: private words for every CPU, then shared words
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 8; w++)
        do_write(c, 12'(12'h400 + 4*w), {8'(c), 8'(w), 8'hA5, 8'(c*8+w)});
    for (int w = 8; w < 32; w++)
      do_write(3, 12'(12'h400 + 4*w), $urandom());
    do_read(2, 12'h404, "R6 R7 private priority word");
    do_read(5, 12'h404, "R6 R7 private priority other CPU");
    do_read(6, 12'h47C, "R6 R7 shared priority last word");

    // R3 read-only words
    do_write(1, 12'h004, 32'hFFFFFFFF);
    do_write(1, 12'h008, 32'h0);
    do_read(0, 12'h004, "R3 type word");
    do_read(7, 12'h008, "R3 ident word");

    // R2 control: only bit 0 kept
    do_write(0, 12'h000, 32'hFFFFFFFE);
    do_read(0, 12'h000, "R2 control bit0 clear");
    do_write(4, 12'h000, 32'hFFFFFFFF);
    do_read(4, 12'h000, "R2 control reads 1");

    // R5 clear-enable word 0 keeps SGIs on
    do_write(2, 12'h100, 32'hFFFF0000);
    do_write(2, 12'h180, 32'hFFFFFFFF);
    do_read(2, 12'h100, "R5 SGI enables forced");

    // R6 banking of word 0
    do_write(1, 12'h100, 32'h00100000);
    do_read(1, 12'h100, "R6 bank of CPU1");
    do_read(3, 12'h100, "R6 bank of CPU3 untouched");
    do_write(6, 12'h204, 32'h80000001);
    do_read(0, 12'h284, "R4 R6 shared pending seen by another CPU");

    // R9 config word 0 forced; R8 compression
    do_write(5, 12'hC00, 32'h0);
    do_read(5, 12'hC00, "R9 config word0 forced edge");
    do_write(5, 12'hC08, 32'h55555555);
    do_read(5, 12'hC08, "R8 even bits dropped");
    do_write(5, 12'hC08, 32'hAAAA0008);
    do_read(1, 12'hC08, "R8 odd bits kept");
    do_write(3, 12'hC04, 32'h8000000A);
    do_read(3, 12'hC04, "R6 R8 private config word 1");

    // R10 read-as-zero / write-ignored
    foreach (raz_list[i]) begin
      do_write(i, raz_list[i], 32'hFFFFFFFF);
      do_read(i, raz_list[i], "R10 RAZ/WI read");
    end
    do_write(0, 12'hFFC, 32'hFFFFFFFF);
    do_read(0, 12'hFFC, "R10 unmapped read");

    // R12 read data holds between reads
    do_read(6, 12'h008, "R12 read");
    held = bus_rdata;
    do_write(6, 12'h000, 32'h0);
    @(negedge clk);
    chk("R12 rdata held", 256'(bus_rdata), 256'(held));

    // Random mix (R4 R6 R7 R8 R10 R11)
    for (int n = 0; n < 3000; n++) begin
      int cpu;
      int k;
      logic [11:0] ad;
      logic [31:0] d;
      cpu = $urandom_range(0, 7);
      k   = $urandom_range(0, 9);
      d   = $urandom();
      case (k)
        0: ad = 12'(4 * $urandom_range(0, 2));
        1: ad = 12'(12'h100 + 4 * $urandom_range(0, 3));
        2: ad = 12'(12'h180 + 4 * $urandom_range(0, 3));
        3: ad = 12'(12'h200 + 4 * $urandom_range(0, 3));
        4: ad = 12'(12'h280 + 4 * $urandom_range(0, 3));
        5: ad = 12'(12'h400 + 4 * $urandom_range(0, 31));
        6: ad = 12'(12'hC00 + 4 * $urandom_range(0, 7));
        7: ad = raz_list[$urandom_range(0, 5)];
        default: ad = 12'($urandom()) & 12'hFFC;
      endcase
      if ($urandom_range(0, 1) == 1) do_write(cpu, ad, d);
      else do_read(cpu, ad, "R4 R6 R7 R8 R10 random read-back");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule